// File: doc/BRIEF.md
# Host Port Request and Acknowledge Handshake

This block sits on the external-device side of a host data port. The port has one receive register, which the processor side loads, and one transmit register, which the processor side drains. The block signals that it needs service on a single active-low request line. An external device answers on a single active-low acknowledge line.

A mode bit sets what the acknowledge means. In interrupt mode, acknowledge is a vectored interrupt acknowledge, and the port drives its vector register onto the data bus. In DMA mode, acknowledge is a transfer strobe. In the read direction the port drives the receive register onto the bus while acknowledge is low. In the write direction the port takes bus data into the transmit register when acknowledge returns high.

The data bus appears as separate in, out and output-enable signals, so the chip pad ring can build the tri-state buffer. Acknowledge is sampled on the block clock. A transfer completes on the first clock that samples acknowledge high after a clock that sampled it low.

Top module: `hostport_dma_hs`

## Requirements
- R1: After reset, both full flags are 0, `host_req_n` is 1 and `d_oe` is 0. All configuration bits and the vector register are 0.
- R2: A clock with `cfg_we` high loads the configuration from `cfg_wdata`: bit 0 enables the request, bit 1 selects DMA mode (1) or interrupt mode (0), and bit 2 selects the direction, read (1) or write (0). A clock with `vec_we` high loads the vector register from `vec_wdata`.
- R3: `host_req_n` is always driven to 0 or 1. It is 0 exactly when the request is enabled and service is needed. Service is needed when the receive register is full (read direction) or when the transmit register is empty (write direction). This holds in both modes.
- R4: In interrupt mode, while `host_ack_n` is 0, `d_oe` is 1 and `d_out` equals the vector register in the same cycle. The acknowledge changes no flag.
- R5: In DMA read mode, while `host_ack_n` is 0, `d_oe` is 1 and `d_out` equals the receive register. The receive full flag clears on the clock that first samples acknowledge high again.
- R6: In DMA write mode, `d_oe` stays 0 during acknowledge. On the clock that first samples acknowledge high again, the transmit register takes the `d_in` value sampled on the last clock with acknowledge low, and the transmit full flag sets.
- R7: In DMA write mode, an acknowledge while the transmit register is full is ignored. `tx_rdata` and `tx_full` keep their values.
- R8: `d_oe` is 0 whenever `host_ack_n` is 1.
- R9: `rx_load` captures `rx_wdata` and sets `rx_full`, and it wins over a read completion in the same clock. `tx_take` clears `tx_full`.
- R10: With the request enable at 0, `host_req_n` stays 1 even when service is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Bit 0 request enable, bit 1 DMA mode, bit 2 read direction |
| vec_we | input | 1 | Vector register write strobe |
| vec_wdata | input | DW | Vector register write data |
| rx_load | input | 1 | Processor side loads the receive register |
| rx_wdata | input | DW | Receive register load data |
| tx_take | input | 1 | Processor side drains the transmit register |
| tx_rdata | output | DW | Transmit register contents |
| rx_full | output | 1 | Receive register holds unread data |
| tx_full | output | 1 | Transmit register holds undrained data |
| host_ack_n | input | 1 | Active-low acknowledge / transfer strobe |
| host_req_n | output | 1 | Active-low service request |
| d_in | input | DW | Data bus input |
| d_out | output | DW | Data bus output value |
| d_oe | output | 1 | Data bus output enable |

## Verification
The bench targets four cases: a read completion that lands in the same clock as a fresh receive load, a write strobe that arrives while the transmit register is still full, a disabled request while service is pending, and reset in the middle of activity. A design that lets the completion beat the load loses a word and negates the request too early. A design that accepts the write while full overwrites undrained data. A design that ignores the enable raises a spurious request. The bench also checks that the write direction never turns on the bus driver and that interrupt mode returns the vector rather than the receive word. Either slip would put two drivers on the bus or return the wrong data.

// File: rtl/hostport_dma_hs.sv
module hostport_dma_hs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_wdata,
  input  logic          vec_we,
  input  logic [DW-1:0] vec_wdata,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_wdata,
  input  logic          tx_take,
  output logic [DW-1:0] tx_rdata,
  output logic          rx_full,
  output logic          tx_full,
  input  logic          host_ack_n,
  output logic          host_req_n,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe
);

  logic          req_en, dma_mode, dir_rd;
  logic [DW-1:0] vec_q, rx_q, tx_q, stage_q;
  logic          rx_full_q, tx_full_q, ack_q;
  logic          ack_rise, rd_done, wr_done, need;

  assign ack_rise = ~ack_q & host_ack_n;
  assign rd_done  = ack_rise & dma_mode & dir_rd;
  assign wr_done  = ack_rise & dma_mode & ~dir_rd & ~tx_full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_en    <= 1'b0;
      dma_mode  <= 1'b0;
      dir_rd    <= 1'b0;
      vec_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      stage_q   <= '0;
      rx_full_q <= 1'b0;
      tx_full_q <= 1'b0;
      ack_q     <= 1'b1;
    end else begin
      ack_q <= host_ack_n;
      if (!host_ack_n) stage_q <= d_in;
      if (cfg_we) {dir_rd, dma_mode, req_en} <= cfg_wdata;
      if (vec_we) vec_q <= vec_wdata;
      if (rx_load) begin
        rx_q      <= rx_wdata;
        rx_full_q <= 1'b1;
      end else if (rd_done) begin
        rx_full_q <= 1'b0;
      end
      if (wr_done) begin
        tx_q      <= stage_q;
        tx_full_q <= 1'b1;
      end else if (tx_take) begin
        tx_full_q <= 1'b0;
      end
    end
  end

  assign need       = dir_rd ? rx_full_q : ~tx_full_q;
  assign host_req_n = ~(req_en & need);
  assign d_oe       = ~host_ack_n & (~dma_mode | dir_rd);
  assign d_out      = dma_mode ? rx_q : vec_q;
  assign tx_rdata   = tx_q;
  assign rx_full    = rx_full_q;
  assign tx_full    = tx_full_q;

  // R3
  req_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(host_req_n));

  // R8
  oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> !host_ack_n);

  // R6
  tx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_full_q) |-> ($past(host_ack_n) && !$past(host_ack_n, 2)));

  // R5
  rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full_q) |-> $past(dma_mode && dir_rd && host_ack_n));

  // R9
  req_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && req_en && dir_rd && !cfg_we) |=> !host_req_n);

endmodule

// File: tb/hostport_dma_hs_bench.sv
`timescale 1ns/1ps
module hostport_dma_hs_bench;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, vec_we = 0, rx_load = 0, tx_take = 0, host_ack_n = 1;
  logic [2:0] cfg_wdata = '0;
  logic [DW-1:0] vec_wdata = '0, rx_wdata = '0, d_in = '0;
  logic [DW-1:0] tx_rdata, d_out;
  logic rx_full, tx_full, host_req_n, d_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hostport_dma_hs #(.DW(DW)) u_hostport_dma_hs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .vec_we(vec_we), .vec_wdata(vec_wdata), .rx_load(rx_load), .rx_wdata(rx_wdata),
    .tx_take(tx_take), .tx_rdata(tx_rdata), .rx_full(rx_full), .tx_full(tx_full),
    .host_ack_n(host_ack_n), .host_req_n(host_req_n), .d_in(d_in),
    .d_out(d_out), .d_oe(d_oe));

  // entry: {cfg[2:0], data}; cfg bit0 enable, bit1 DMA, bit2 read
  localparam logic [34:0] VECS [6] = '{
    {3'b111, 32'hA5A5_0001}, {3'b011, 32'h1234_5678},
    {3'b001, 32'h0000_0040}, {3'b101, 32'h0000_0041},
    {3'b111, 32'hFFFF_FFFF}, {3'b011, 32'h0000_0000}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_cfg(input logic [2:0] c);
    cfg_wdata = c; cfg_we = 1; tick(); cfg_we = 0;
  endtask

  task automatic ack_low(input logic [31:0] data);
    host_ack_n = 0; d_in = data; #1;
  endtask

  task automatic ack_high();
    tick(); host_ack_n = 1; d_in = '0; tick();
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    chk(rx_full == 0 && tx_full == 0, "R1 flags", {rx_full, tx_full}, 0);
    chk(host_req_n == 1, "R1 req", host_req_n, 1);
    chk(d_oe == 0, "R1 oe", d_oe, 0);
    set_cfg(3'b011);
    chk(host_req_n == 0, "R2 cfg enables request", host_req_n, 0);
    set_cfg(3'b000);

    foreach (VECS[i]) begin
      logic [2:0] c; logic [31:0] w;
      c = VECS[i][34:32]; w = VECS[i][31:0];
      set_cfg(c);
      if (c[1] && c[2]) begin
        rx_wdata = w; rx_load = 1; tick(); rx_load = 0;
        chk(host_req_n == 0, "R3 rd req", host_req_n, 0);
        ack_low(32'hDEAD_BEEF);
        chk(d_oe == 1 && d_out == w, "R5 rd drive", d_out, w);
        ack_high();
        chk(rx_full == 0 && host_req_n == 1, "R5 rd done", {rx_full, host_req_n}, 1);
      end else if (c[1]) begin
        chk(host_req_n == 0, "R3 wr req", host_req_n, 0);
        ack_low(w);
        chk(d_oe == 0, "R6 no drive", d_oe, 0);
        ack_high();
        chk(tx_full == 1 && tx_rdata == w, "R6 wr capture", tx_rdata, w);
        chk(host_req_n == 1, "R6 req negated", host_req_n, 1);
        tx_take = 1; tick(); tx_take = 0;
        chk(tx_full == 0, "R9 take", tx_full, 0);
      end else begin
        vec_wdata = w; vec_we = 1; tick(); vec_we = 0;
        ack_low(32'h0);
        chk(d_oe == 1 && d_out == w, "R4 vector", d_out, w);
        ack_high();
        chk(host_req_n == c[2], "R3 irq req", host_req_n, {31'b0, c[2]});
        chk(rx_full == 0 && tx_full == 0, "R4 flags kept", {rx_full, tx_full}, 0);
      end
    end

    chk(d_oe == 0, "R8 idle oe", d_oe, 0);

    // R7: write while full is ignored
    set_cfg(3'b011);
    ack_low(32'h1111_1111); ack_high();
    ack_low(32'h2222_2222); ack_high();
    chk(tx_full == 1 && tx_rdata == 32'h1111_1111, "R7 ignored", tx_rdata, 32'h1111_1111);
    tx_take = 1; tick(); tx_take = 0;

    // R10: disabled request
    set_cfg(3'b010);
    chk(host_req_n == 1, "R10 disabled", host_req_n, 1);

    // R9: load wins over completion in the same clock
    set_cfg(3'b111);
    rx_wdata = 32'hAAAA_0000; rx_load = 1; tick(); rx_load = 0;
    ack_low(32'h0); tick(); host_ack_n = 1;
    rx_wdata = 32'hBBBB_0000; rx_load = 1; tick(); rx_load = 0;
    chk(rx_full == 1 && host_req_n == 0, "R9 load wins", {rx_full, host_req_n}, 2'b10);
    ack_low(32'h0);
    chk(d_out == 32'hBBBB_0000, "R9 new word", d_out, 32'hBBBB_0000);
    host_ack_n = 1; tick();

    // R1: reset mid-activity
    rst_n = 0; tick(); rst_n = 1; tick();
    chk(rx_full == 0 && tx_full == 0 && host_req_n == 1, "R1 rerst", {rx_full, tx_full, host_req_n}, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule